// File: doc/BRIEF.md
# GPIO Input Debounce Filter

This block cleans up a bank of general-purpose inputs before they reach the edge/level interrupt detector and the register that software reads as the external port value. Every input first passes through a two-flop synchronizer clocked by the debounce reference clock. A pin whose filter enable is low is forwarded from the synchronizer unchanged. A pin whose filter enable is high is forwarded only after the synchronized level has been seen twice in a row at that pin's sample points.

Each filtered pin also chooses where its sample points come from. With its divider-use bit low it samples on every reference clock cycle. With that bit high it samples on a shared slow tick. The tick comes from a free-running counter whose period is set by a 24-bit divide value V, giving one tick every 2×(V+1) reference cycles. The control bits and the divide value are plain inputs, driven from register storage that lives outside this block.

Top module: `gpio_debounce`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every bit of `pin_out` is 0, whatever `pin_in` is.
- R2: A pin with `deb_en` low drives `pin_out` with its `pin_in` value from two rising edges earlier, so that even a one-cycle pulse passes through.
- R3: A pin with `deb_en` high and `div_en` low that changes level and holds it shows the new level on `pin_out` at the fourth rising edge after the change, and not before.
- R4: A filtered pin passes a new level only after two consecutive sample points have both seen that level. A pulse shorter than two sample points never reaches `pin_out`.
- R5: The divided sample tick repeats every 2×(V+1) reference cycles, where V is the 24-bit `div_val`. The longest interval is therefore 2×2^24 cycles.
- R6: When `div_val` takes a new value V, the tick counter restarts at zero. A divided pin that changes level in that same cycle and holds it shows the new level at rising edge 4×(V+1)+1 after the change, and not at edge 4×(V+1).
- R7: Driving `deb_en` low clears the filter history of that pin. When it is raised again with the input at 1, the output reads 0 until two further rising edges have passed.
- R8: Pins are independent. Bit i of `pin_out` depends only on bit i of `pin_in`, `deb_en` and `div_en`, together with the shared tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debounce reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS (32) | Raw asynchronous pin levels |
| deb_en | input | NPINS (32) | Per-pin filter enable |
| div_en | input | NPINS (32) | Per-pin selection of the divided tick as sample point |
| div_val | input | DIVW (24) | Divide value V; tick period is 2×(V+1) cycles |
| pin_out | output | NPINS (32) | Synchronized and filtered pin levels |

## Verification
The phase of the free-running tick counter cannot be seen at the ports, so divided-mode latencies cannot be predicted from arbitrary stimulus. The bench therefore changes `div_val` and the pin level at the same negative edge. The restart rule then fixes the counter phase, and the exact edges 4×(V+1) and 4×(V+1)+1 can be checked for two different divide values. Glitch rejection in divided mode is checked with pulses shorter than one tick period, which holds for any counter phase.

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int NPINS = 32,
  parameter int DIVW  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] deb_en,
  input  logic [NPINS-1:0] div_en,
  input  logic [DIVW-1:0]  div_val,
  output logic [NPINS-1:0] pin_out
);
  localparam int CNTW = DIVW + 1;

  logic [NPINS-1:0] sync1, sync2, samp_q, filt_q;
  logic [NPINS-1:0] samp_en, agree, samp_d, filt_d;
  logic [DIVW-1:0]  div_q;
  logic [CNTW-1:0]  cnt, cnt_end;
  logic             div_chg, tick;

  assign div_chg = div_val != div_q;
  assign cnt_end = {div_q, 1'b1};
  assign tick    = !div_chg && (cnt == cnt_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt   <= '0;
    end else if (div_chg) begin
      div_q <= div_val;
      cnt   <= '0;
    end else if (cnt >= cnt_end) begin
      cnt   <= '0;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  assign samp_en = ~div_en | {NPINS{tick}};
  assign agree   = samp_en & ~(sync2 ^ samp_q);
  assign samp_d  = deb_en & ((samp_en & sync2) | (~samp_en & samp_q));
  assign filt_d  = deb_en & ((agree & sync2) | (~agree & filt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      filt_q <= '0;
    end else begin
      samp_q <= samp_d;
      filt_q <= filt_d;
    end
  end

  assign pin_out = (deb_en & filt_q) | (~deb_en & sync2);
endmodule

// File: rtl/gpio_debounce_chk.sv
module gpio_debounce_chk #(
  parameter int NPINS = 32,
  parameter int DIVW  = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] deb_en,
  input logic [NPINS-1:0] pin_out,
  input logic [DIVW-1:0]  div_val,
  input logic [DIVW-1:0]  div_q,
  input logic [DIVW:0]    cnt,
  input logic [NPINS-1:0] sync2,
  input logic [NPINS-1:0] samp_q,
  input logic [NPINS-1:0] filt_q
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (((pin_out ^ $past(pin_in, 2)) & ~deb_en) == '0));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= {div_q, 1'b1});

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && $past(div_val != div_q)) |-> (cnt == '0 && div_q == $past(div_val)));

  p_two_samples_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1) |-> (((filt_q ^ $past(filt_q)) & $past(deb_en) &
                        ((filt_q ^ $past(samp_q)) | (filt_q ^ $past(sync2)))) == '0));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1) |-> (((filt_q | samp_q) & ~$past(deb_en)) == '0));
endmodule

bind gpio_debounce gpio_debounce_chk #(.NPINS(NPINS), .DIVW(DIVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .deb_en(deb_en), .pin_out(pin_out),
  .div_val(div_val), .div_q(div_q), .cnt(cnt), .sync2(sync2),
  .samp_q(samp_q), .filt_q(filt_q)
);

// File: tb/sim_gpio_debounce.sv
module sim_gpio_debounce;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_in = '0, deb_en = '0, div_en = '0, pin_out;
  logic [23:0] div_val = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_debounce u0 (.clk(clk), .rst_n(rst_n), .pin_in(pin_in), .deb_en(deb_en),
                    .div_en(div_en), .div_val(div_val), .pin_out(pin_out));

  localparam logic [31:0] MASK = 32'h0F0F_00FF;
  localparam logic [31:0] VEC [0:7] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hA5A5_5A5A,
    32'h5A5A_A5A5, 32'h0000_FFFF, 32'hFFFF_0000, 32'h1234_5678, 32'h8000_0001};

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: pin_out=%h expected=%h", tag, got, exp);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] prev;
    // R1: outputs low in reset even with inputs high
    pin_in = '1;
    step(3);
    check("R1 in reset", pin_out, 32'h0);
    pin_in = '0;
    step(2);
    rst_n = 1'b1;
    check("R1 after release", pin_out, 32'h0);
    step(3);

    // table walk: R2/R8 after two edges, R3 after four
    deb_en = MASK;
    prev = '0;
    for (int i = 0; i < 8; i++) begin
      pin_in = VEC[i];
      step(2);
      check("R2/R8 mixed pins", pin_out, (VEC[i] & ~MASK) | (prev & MASK));
      step(2);
      check("R3 settled", pin_out, VEC[i]);
      prev = VEC[i];
    end

    // R3 exact latency
    deb_en = '1; pin_in = '0;
    step(6);
    pin_in = 32'h1;
    step(3);
    check("R3 not before edge 4", pin_out, 32'h0);
    step(1);
    check("R3 at edge 4", pin_out, 32'h1);

    // R4 one-cycle glitch rejected
    pin_in = '0;
    step(6);
    pin_in = 32'hFFFF_0000;
    step(1);
    pin_in = '0;
    for (int k = 0; k < 6; k++) begin
      step(1);
      check("R4 glitch", pin_out, 32'h0);
    end

    // R7 clearing on disable
    pin_in = '1;
    step(6);
    check("R7 setup", pin_out, 32'hFFFF_FFFF);
    deb_en = '0;
    #0.1 check("R7 bypass while off", pin_out, 32'hFFFF_FFFF);
    step(1);
    deb_en = '1;
    #0.1 check("R7 cleared", pin_out, 32'h0);
    step(1);
    check("R7 one sample", pin_out, 32'h0);
    step(1);
    check("R7 refilled", pin_out, 32'hFFFF_FFFF);

    // R6 restart with divided pin 0, undivided pin 1
    div_en = 32'h1; div_val = 24'd0; pin_in = '0;
    step(20);
    check("R6 setup", pin_out, 32'h0);
    div_val = 24'd100;
    step(50);
    pin_in = 32'h3; div_val = 24'd2;
    step(4);
    check("R6/R8 undivided pin", pin_out, 32'h2);
    step(8);
    check("R6 not at edge 12", pin_out, 32'h2);
    step(1);
    check("R6 at edge 13", pin_out, 32'h3);

    // R5 period with V=3: pin 0 falls at edge 17
    pin_in = 32'h0; div_val = 24'd3;
    step(16);
    check("R5 not at edge 16", pin_out, 32'h1);
    step(1);
    check("R5 at edge 17", pin_out, 32'h0);

    // R4 divided: pulse shorter than one tick period rejected
    pin_in = 32'h1;
    step(3);
    pin_in = 32'h0;
    for (int k = 0; k < 4; k++) begin
      step(10);
      check("R4 divided glitch", pin_out, 32'h0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule